// File: doc/BRIEF.md
# Error Flood Cascade with Self-Erasing State Register

This block sits at the boundary between the combinational core of a dual-rail encoded datapath and its outputs and state register. Each logical bit travels as a pair of wires: logic 1 is the pair 10, logic 0 is the pair 01, and 00 is the error symbol. The pair 11 is not a legal symbol and is handled as an error as well. The block monitors the output-bound pairs, the next-state pairs, the incoming primary-input pairs and the pairs of its own current state. If every monitored pair is legal, data passes through unchanged. If any single pair is illegal, every output pair and every next-state pair is forced to 00.

The monitored pairs run through a chain of two-pair cascade gadgets built from AND and OR gates only, with inversion used only on gadget inputs. The output-bound pairs come first in the chain, so an error that appears on a state-bound pair still clears the outputs in the same cycle. A flooded next state is stored as all 00 at the next clock edge. Because the current state is monitored too, the erased state keeps flooding the block, and the decoded outputs read zero from then on until reset. A registered, sticky flag records that an error has been seen.

Top module: `fault_flood_store`

## Requirements
- R1: While reset is asserted and just after it, the state register holds the encoded form of the parameter INIT_STATE (state bit i on state_q[2i+1:2i], 1 as 10, 0 as 01) and destroyed is 0.
- R2: When every monitored pair is 10 or 01, dec_out[i] equals the upper wire out_enc[2i+1] in the same cycle, and state_q takes nxt_enc at the next rising clock edge.
- R3: A 00 pair on any output-bound input drives every dec_out bit to 0 in the same cycle and loads state_q with all zeros at the next edge.
- R4: A 00 pair on any next-state input drives every dec_out bit to 0 in the same cycle and loads state_q with all zeros at the next edge.
- R5: A 00 pair on any primary-input pair drives every dec_out bit to 0 in the same cycle and loads state_q with all zeros at the next edge.
- R6: Once state_q is all zeros, dec_out stays 0 and state_q stays all zeros for every later cycle up to reset, whatever legal values the inputs carry.
- R7: destroyed rises at the first clock edge that sees an illegal monitored pair and stays 1 until reset; it never rises without one.
- R8: A pair 11 on any monitored input is handled exactly like 00.
- R9: No pair of state_q ever holds 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| out_enc | input | 2*N_OUT | Encoded output-bound pairs from the core |
| nxt_enc | input | 2*N_ST | Encoded next-state pairs from the core |
| in_enc | input | 2*N_IN | Encoded primary-input pairs, monitored only |
| dec_out | output | N_OUT | Decoded outputs (upper wire of each flooded pair) |
| state_q | output | 2*N_ST | Registered encoded state, fed back to the core |
| destroyed | output | 1 | Sticky flag: an illegal pair has been seen |

## Verification
The bench builds the block with three output pairs, two state pairs, two primary-input pairs and an initial state of binary 10, so that every position in the chain is used: a leading output pair, an output pair in the middle, a next-state pair behind the outputs, and a primary-input pair near the tail. With those sizes one error can be placed on each class of monitored pair in turn and the flood to all outputs and both state pairs observed. The small state width also lets the reset value and the erased value be told apart bit for bit.

// File: rtl/flood_pkg.sv
// Shared encoding for the dual-rail error flood block.
// Assumes each logical bit is carried as a two-wire pair, upper wire first.
package flood_pkg;
    typedef logic [1:0] pair_t;
    localparam pair_t PAIR_ERR  = 2'b00;
    localparam pair_t PAIR_ONE  = 2'b10;
    localparam pair_t PAIR_ZERO = 2'b01;
endpackage

// File: rtl/flood_gadget.sv
// Two-pair cascade gadget: passes both pairs when both are legal (01 or 10),
// otherwise drives both outputs to 00. Built from AND/OR with inversion only
// on inputs, so it never produces 11. Assumes nothing about input legality.
module flood_gadget
    import flood_pkg::*;
(
    input  pair_t a_i,
    input  pair_t b_i,
    output pair_t a_o,
    output pair_t b_o
);
    logic a_ok;
    logic b_ok;

    // Legality of each input pair and gating of both pairs by their joint legality.
    always_comb begin
        a_ok = (a_i[1] & ~a_i[0]) | (~a_i[1] & a_i[0]);
        b_ok = (b_i[1] & ~b_i[0]) | (~b_i[1] & b_i[0]);
        a_o  = a_i & {2{a_ok & b_ok}};
        b_o  = b_i & {2{a_ok & b_ok}};
    end
endmodule

// File: rtl/flood_chain.sv
// Cascade chain: a forward pass over kept pairs (outputs first, then next
// state) and tail pairs (inputs, current state) builds a carry that is 00 if
// any pair is illegal; a backward pass re-gates every kept pair with that
// carry. Assumes kept pairs are ordered outputs first.
module flood_chain
    import flood_pkg::*;
#(
    parameter int NK = 5,
    parameter int NT = 4
) (
    input  logic [2*NK-1:0] kept_i,
    input  logic [2*NT-1:0] tail_i,
    output logic [2*NK-1:0] kept_o,
    output logic            err_o
);
    localparam int NP = NK + NT;

    pair_t items [NP];
    pair_t fcar  [NP+1];
    pair_t bcar  [NK+1];

    // Unpack kept and tail pairs into one ordered list, outputs at index 0.
    always_comb begin
        for (int i = 0; i < NK; i++) items[i]      = kept_i[2*i +: 2];
        for (int j = 0; j < NT; j++) items[NK + j] = tail_i[2*j +: 2];
    end

    assign fcar[0] = PAIR_ONE;

    for (genvar g = 0; g < NP; g++) begin : g_fwd
        pair_t ca, it;
        flood_gadget u_g (.a_i(fcar[g]), .b_i(items[g]), .a_o(ca), .b_o(it));
        // Join: carry stays legal only while the gated item is non-zero.
        assign fcar[g+1] = ca & {2{|it}};
    end

    assign bcar[NK] = fcar[NP];

    for (genvar k = NK - 1; k >= 0; k--) begin : g_bwd
        pair_t gk;
        flood_gadget u_g (.a_i(bcar[k+1]), .b_i(items[k]), .a_o(bcar[k]), .b_o(gk));
        assign kept_o[2*k +: 2] = gk;
    end

    assign err_o = ~|bcar[0];
endmodule

// File: rtl/fault_flood_store.sv
// Top: error flood cascade in front of the outputs and the encoded state
// register. Any illegal monitored pair floods all outputs and the next
// state with 00; the stored state then erases itself. Synchronous active-low
// reset loads the encoded INIT_STATE. Assumes the core supplies pairs.
module fault_flood_store
    import flood_pkg::*;
#(
    parameter int                N_OUT      = 3,
    parameter int                N_ST       = 2,
    parameter int                N_IN       = 2,
    parameter logic [N_ST-1:0]   INIT_STATE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*N_OUT-1:0]  out_enc,
    input  logic [2*N_ST-1:0]   nxt_enc,
    input  logic [2*N_IN-1:0]   in_enc,
    output logic [N_OUT-1:0]    dec_out,
    output logic [2*N_ST-1:0]   state_q,
    output logic                destroyed
);
    localparam int NK = N_OUT + N_ST;
    localparam int NT = N_IN + N_ST;

    logic [2*N_ST-1:0] init_enc;
    logic [2*NK-1:0]   kept_g;
    logic              err;

    for (genvar s = 0; s < N_ST; s++) begin : g_init
        assign init_enc[2*s +: 2] = INIT_STATE[s] ? PAIR_ONE : PAIR_ZERO;
    end

    flood_chain #(.NK(NK), .NT(NT)) u_chain (
        .kept_i ({nxt_enc, out_enc}),
        .tail_i ({state_q, in_enc}),
        .kept_o (kept_g),
        .err_o  (err)
    );

    // Decode each flooded output pair by its upper wire.
    always_comb begin
        for (int i = 0; i < N_OUT; i++) dec_out[i] = kept_g[2*i+1];
    end

    // State register: reset to encoded initial value, else take flooded next state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= init_enc;
        else        state_q <= kept_g[2*NK-1 : 2*N_OUT];
    end

    // Sticky destroyed flag, set by any error seen at a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   destroyed <= 1'b0;
        else if (err) destroyed <= 1'b1;
    end
endmodule

// File: rtl/flood_chk.sv
// Checker for fault_flood_store, attached by bind. Observes ports only.
module flood_chk #(
    parameter int N_OUT = 3,
    parameter int N_ST  = 2,
    parameter int N_IN  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*N_OUT-1:0] out_enc,
    input logic [2*N_ST-1:0]  nxt_enc,
    input logic [2*N_IN-1:0]  in_enc,
    input logic [N_OUT-1:0]   dec_out,
    input logic [2*N_ST-1:0]  state_q,
    input logic               destroyed
);
    logic bad_any;
    logic st_11;

    // Flag any monitored pair that is neither 01 nor 10.
    always_comb begin
        bad_any = 1'b0;
        st_11   = 1'b0;
        for (int i = 0; i < N_OUT; i++) if (out_enc[2*i+1] == out_enc[2*i]) bad_any = 1'b1;
        for (int i = 0; i < N_ST; i++)  if (nxt_enc[2*i+1] == nxt_enc[2*i]) bad_any = 1'b1;
        for (int i = 0; i < N_IN; i++)  if (in_enc[2*i+1] == in_enc[2*i])   bad_any = 1'b1;
        for (int i = 0; i < N_ST; i++)  if (state_q[2*i+1] == state_q[2*i]) bad_any = 1'b1;
        for (int i = 0; i < N_ST; i++)  if (state_q[2*i +: 2] == 2'b11)     st_11   = 1'b1;
    end

    // R3 R4 R5 R8: any illegal pair clears outputs now
    p_flood_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bad_any |-> dec_out == '0);

    // R3 R4 R5: any illegal pair erases the state at the next edge
    p_erase_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_any |=> state_q == '0);

    // R2: clean cycle loads next state unchanged
    p_pass_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_any |=> state_q == $past(nxt_enc));

    // R7: destroyed is sticky
    p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        destroyed |=> destroyed);

    // R7: destroyed rises only after an illegal pair
    p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(destroyed) |-> $past(bad_any));

    // R6: erased state stays erased
    p_stay_erased_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == '0 |=> state_q == '0);

    // R9: no 11 pair in the stored state
    p_no_11_r9: assert property (@(posedge clk) disable iff (!rst_n) !st_11);
endmodule

bind fault_flood_store flood_chk #(.N_OUT(N_OUT), .N_ST(N_ST), .N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_enc(out_enc), .nxt_enc(nxt_enc),
    .in_enc(in_enc), .dec_out(dec_out), .state_q(state_q), .destroyed(destroyed)
);

// File: tb/sim_fault_flood_store.sv
`timescale 1ns/1ps
module sim_fault_flood_store;
    localparam int N_OUT = 3;
    localparam int N_ST  = 2;
    localparam int N_IN  = 2;
    localparam logic [N_ST-1:0] INIT = 2'b10;
    localparam int NV = 6;
    // Each row: {out bits[2:0], next-state bits[1:0], input bits[1:0]}
    localparam logic [6:0] VEC [NV] = '{7'b101_10_01, 7'b010_01_10, 7'b111_11_11,
                                        7'b000_00_00, 7'b011_10_00, 7'b100_01_11};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*N_OUT-1:0] out_enc = '0;
    logic [2*N_ST-1:0]  nxt_enc = '0;
    logic [2*N_IN-1:0]  in_enc  = '0;
    logic [N_OUT-1:0]   dec_out;
    logic [2*N_ST-1:0]  state_q;
    logic               destroyed;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fault_flood_store #(.N_OUT(N_OUT), .N_ST(N_ST), .N_IN(N_IN), .INIT_STATE(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .out_enc(out_enc), .nxt_enc(nxt_enc), .in_enc(in_enc),
        .dec_out(dec_out), .state_q(state_q), .destroyed(destroyed));

    function automatic logic [7:0] enc(input logic [3:0] b, input int n);
        logic [7:0] r = '0;
        for (int i = 0; i < n; i++) r[2*i +: 2] = b[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        out_enc = enc(4'b0101, N_OUT)[2*N_OUT-1:0];
        nxt_enc = enc(4'b0001, N_ST)[2*N_ST-1:0];
        in_enc  = enc(4'b0010, N_IN)[2*N_IN-1:0];
        @(posedge clk); @(posedge clk);
        #1;
        check("R1 state", 8'(state_q), 8'(enc(4'(INIT), N_ST)));
        check("R1 flag", 8'(destroyed), 8'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive an error scenario, check same-cycle flood and the next-edge erase.
    task automatic flood_case(input string req, input logic [5:0] o, input logic [3:0] nx,
                              input logic [3:0] ii);
        @(negedge clk);
        out_enc = o; nxt_enc = nx; in_enc = ii;
        #1;
        check({req, " outputs same cycle"}, 8'(dec_out), 8'h0);
        @(posedge clk); #1;
        check({req, " state erased"}, 8'(state_q), 8'h0);
        check({req, " flag R7"}, 8'(destroyed), 8'h1);
    endtask

    initial begin
        do_reset();
        // R2: clean vectors pass through
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            out_enc = enc(4'(VEC[v][6:4]), N_OUT)[2*N_OUT-1:0];
            nxt_enc = enc(4'(VEC[v][3:2]), N_ST)[2*N_ST-1:0];
            in_enc  = enc(4'(VEC[v][1:0]), N_IN)[2*N_IN-1:0];
            #1;
            check("R2 decode", 8'(dec_out), 8'(VEC[v][6:4]));
            @(posedge clk); #1;
            check("R2 state load", 8'(state_q), 8'(enc(4'(VEC[v][3:2]), N_ST)));
            check("R7 no flag", 8'(destroyed), 8'h0);
        end

        // R3: middle output pair 00
        flood_case("R3", 6'b10_00_10, 4'b10_01, 4'b01_10);
        // R6: legal inputs afterwards leave everything erased
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            out_enc = 6'b10_10_10; nxt_enc = 4'b10_10; in_enc = 4'b10_01;
            #1;
            check("R6 outputs held zero", 8'(dec_out), 8'h0);
            @(posedge clk); #1;
            check("R6 state held erased", 8'(state_q), 8'h0);
            check("R7 flag held", 8'(destroyed), 8'h1);
        end

        do_reset();
        // R4: error on a next-state pair still clears outputs this cycle
        flood_case("R4", 6'b10_10_10, 4'b00_10, 4'b01_10);

        do_reset();
        // R5: error on a primary-input pair
        flood_case("R5", 6'b10_01_10, 4'b10_01, 4'b00_01);

        do_reset();
        // R8 R9: pair 11 on next state behaves as error, stored pairs never 11
        flood_case("R8 R9", 6'b01_10_10, 4'b11_10, 4'b01_01);

        do_reset();
        // R8: pair 11 on leading output pair
        flood_case("R8", 6'b10_10_11, 4'b10_01, 4'b10_10);
        done = 1;
    end

    initial begin
        for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule